// File: doc/BRIEF.md
# Digital CVSD Voice Codec Core

This core is a synchronous continuously variable slope delta modulation codec. Signed 12-bit samples stand in for the analog audio on both sides. A single system clock runs everything. Two one-cycle strobes, `bclk_rise` and `bclk_fall`, mark the rising and falling edges of the bit clock. Each bit period carries exactly one NRZ bit.

In encode mode, the input sample is compared with the internal signal estimate at the rising strobe. The resulting bit leaves on `serial_out` at the falling strobe. In decode mode, the bit is taken from `serial_in` at the rising strobe instead.

At every falling strobe the applied bit moves the estimate up or down by the current step and subtracts a leak. The estimate is held with 4 fraction bits. A syllabic filter adapts the step size: it grows while the last three bits agree and otherwise decays. Encode and decode share this datapath, so a decoder fed with the encoder's bit stream tracks the encoder exactly.

Three further features act on the estimate:
- An active-low AGC flag marks large signals.
- A clamp at three-quarters of full scale stops the step and its adaptation.
- A force-idle input replaces the data with an alternating quieting pattern.

Top module: `cvsd_codec`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets the estimate to 0, the step to its minimum of 4 LSB, `serial_out` to 0, the idle toggle to 1 and the bit history to 3'b010. After reset, `agc_n` reads 1.
- R2: At a cycle with `bclk_rise`, in encode mode (`mode_enc`=1), the pending bit becomes 1 when `sample_in` is greater than or equal to the estimate, with the sample scaled by 16. Otherwise the pending bit becomes 0. `serial_out` changes only in the cycle after a `bclk_fall`, when it takes the applied bit.
- R3: At a cycle with `bclk_rise`, in decode mode (`mode_enc`=0), the pending bit is the value of `serial_in`.
- R4: At each `bclk_fall` outside the clamp, the estimate E is updated as follows. E is held in 1/16 LSB units. The new E is E plus the step (applied bit 1) or minus the step (applied bit 0), minus floor(E/16). `est_out` is floor(E/16). Between falls, `est_out` is stable.
- R5: At each `bclk_fall` outside the clamp, the step S becomes S - floor(S/64). If the applied bit and the two before it are all equal, a further 8 LSB is added. The result is bounded to the range 4 LSB to 256 LSB.
- R6: `agc_n` is 0 exactly when `est_out` >= 1024 or `est_out` <= -1024. It changes only after a `bclk_fall`.
- R7: When |E| >= 1536 LSB at a `bclk_fall`, the step is held and the step term is dropped, so only the leak applies. The estimate is always limited to ±1536 LSB.
- R8: With `force_idle` high at a `bclk_fall`, the applied bit is the idle toggle, which then inverts. Over consecutive idle falls, `serial_out` alternates and the estimate settles to a square wave at half the bit rate.
- R9: A decoder that is reset and then fed, bit by bit, the encoder's `serial_out` stream produces the same `est_out` sequence as the encoder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bclk_rise | input | 1 | One-cycle strobe: rising edge of the bit clock |
| bclk_fall | input | 1 | One-cycle strobe: falling edge of the bit clock |
| mode_enc | input | 1 | 1 selects encode, 0 selects decode |
| sample_in | input | 12 | Signed input sample (encode) |
| serial_in | input | 1 | NRZ data bit (decode) |
| force_idle | input | 1 | Forces the quieting pattern |
| serial_out | output | 1 | NRZ data bit, updated after falls |
| est_out | output | 12 | Signed recovered estimate |
| agc_n | output | 1 | Low while \|estimate\| is at least half scale |

## Verification
The assertions check on every cycle that:
- `serial_out`, `est_out` and `agc_n` move only after a falling strobe;
- the step stays within its bounds and is frozen during a clamped update;
- the estimate never leaves the clamp window;
- consecutive idle falls alternate the output bit.

The bench's scenarios cover what needs history or arithmetic. They check the exact leak and step-adaptation values under slope overload and under alternating input, the clamp being entered and left, the AGC threshold crossing in both polarities, and the bit-exact match between an encoder run and a decoder replaying its stream.

// File: rtl/cvsd_pkg.sv
package cvsd_pkg;

  // floor(x / 2**sh), by arithmetic shift on a signed value
  function automatic int leak_of(input int x, input int sh);
    return x >>> sh;
  endfunction

  // bound a value into [lo, hi]
  function automatic int bound(input int x, input int lo, input int hi);
    if (x < lo) return lo;
    if (x > hi) return hi;
    return x;
  endfunction

  // syllabic step adaptation
  function automatic int step_next(input int s, input int sh, input bit ovl,
                                   input int inc, input int lo, input int hi);
    int t;
    t = s - (s >>> sh) + (ovl ? inc : 0);
    return bound(t, lo, hi);
  endfunction

  // leaky integrator update; the step term is skipped while clamped
  function automatic int est_next(input int e, input int s, input bit up,
                                  input bit clamped, input int sh, input int lim);
    int t;
    t = e - leak_of(e, sh);
    if (!clamped) t = up ? t + s : t - s;
    return bound(t, -lim, lim);
  endfunction

endpackage

// File: rtl/cvsd_bit_path.sv
module cvsd_bit_path #(
  parameter int W    = 12,
  parameter int FRAC = 4,
  localparam int EW  = W + FRAC
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bclk_rise,
  input  logic                 bclk_fall,
  input  logic                 mode_enc,
  input  logic signed [W-1:0]  sample_in,
  input  logic                 serial_in,
  input  logic                 force_idle,
  input  logic signed [EW-1:0] est,
  output logic                 apply_bit,
  output logic                 serial_out
);
  logic                 pend_q;
  logic                 tgl_q;
  logic signed [EW-1:0] samp_x;
  logic                 cmp_bit;

  assign samp_x    = $signed({sample_in, {FRAC{1'b0}}});
  assign cmp_bit   = (samp_x >= est);
  assign apply_bit = force_idle ? tgl_q : pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= 1'b0;
      tgl_q      <= 1'b1;
      serial_out <= 1'b0;
    end else begin
      if (bclk_rise) pend_q <= mode_enc ? cmp_bit : serial_in;
      if (bclk_fall) begin
        serial_out <= apply_bit;
        if (force_idle) tgl_q <= ~tgl_q;
      end
    end
  end
endmodule

// File: rtl/cvsd_step_adapt.sv
module cvsd_step_adapt
  import cvsd_pkg::*;
#(
  parameter int W        = 12,
  parameter int FRAC     = 4,
  parameter int SYL_SH   = 6,
  parameter int RUN_LEN  = 3,
  parameter int STEP_MIN = 4,
  parameter int STEP_MAX = 256,
  parameter int STEP_INC = 8,
  localparam int EW      = W + FRAC,
  localparam int S_MIN   = STEP_MIN << FRAC,
  localparam int S_MAX   = STEP_MAX << FRAC,
  localparam int S_INC   = STEP_INC << FRAC
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bclk_fall,
  input  logic          apply_bit,
  input  logic          clamp_active,
  output logic [EW-1:0] step,
  output logic          overload
);
  logic [RUN_LEN-1:0] hist_q;
  logic [RUN_LEN-1:0] hist_n;
  logic [RUN_LEN-1:0] rst_pat;

  generate
    for (genvar i = 0; i < RUN_LEN; i++) begin : g_pat
      assign rst_pat[i] = i[0];
    end
  endgenerate

  assign hist_n   = {hist_q[RUN_LEN-2:0], apply_bit};
  assign overload = (&hist_n) | (~|hist_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= rst_pat;
      step   <= EW'(S_MIN);
    end else if (bclk_fall) begin
      hist_q <= hist_n;
      if (!clamp_active)
        step <= EW'(step_next(int'(step), SYL_SH, overload, S_INC, S_MIN, S_MAX));
    end
  end
endmodule

// File: rtl/cvsd_integrator.sv
module cvsd_integrator
  import cvsd_pkg::*;
#(
  parameter int W       = 12,
  parameter int FRAC    = 4,
  parameter int LEAK_SH = 4,
  localparam int EW     = W + FRAC,
  localparam int FS     = 1 << (W - 1),
  localparam int LIM    = (FS * 3 / 4) << FRAC
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bclk_fall,
  input  logic                 apply_bit,
  input  logic [EW-1:0]        step,
  output logic signed [EW-1:0] est,
  output logic                 clamp_active
);
  int e_i;

  assign e_i          = int'(est);
  assign clamp_active = (e_i >= LIM) || (e_i <= -LIM);

  always_ff @(posedge clk) begin
    if (rst) est <= '0;
    else if (bclk_fall)
      est <= EW'(est_next(e_i, int'(step), apply_bit, clamp_active, LEAK_SH, LIM));
  end
endmodule

// File: rtl/cvsd_codec.sv
module cvsd_codec #(
  parameter int W        = 12,
  parameter int FRAC     = 4,
  parameter int LEAK_SH  = 4,
  parameter int SYL_SH   = 6,
  parameter int RUN_LEN  = 3,
  parameter int STEP_MIN = 4,
  parameter int STEP_MAX = 256,
  parameter int STEP_INC = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bclk_rise,
  input  logic                bclk_fall,
  input  logic                mode_enc,
  input  logic signed [W-1:0] sample_in,
  input  logic                serial_in,
  input  logic                force_idle,
  output logic                serial_out,
  output logic signed [W-1:0] est_out,
  output logic                agc_n
);
  localparam int EW   = W + FRAC;
  localparam int HALF = 1 << (W - 2);

  logic signed [EW-1:0] est_w;
  logic [EW-1:0]        step_w;
  logic                 bit_w;
  logic                 clamp_w;
  logic                 ovl_w;
  int                   eo_i;

  cvsd_bit_path #(.W(W), .FRAC(FRAC)) u_bits (
    .clk(clk), .rst(rst), .bclk_rise(bclk_rise), .bclk_fall(bclk_fall),
    .mode_enc(mode_enc), .sample_in(sample_in), .serial_in(serial_in),
    .force_idle(force_idle), .est(est_w), .apply_bit(bit_w),
    .serial_out(serial_out)
  );

  cvsd_step_adapt #(.W(W), .FRAC(FRAC), .SYL_SH(SYL_SH), .RUN_LEN(RUN_LEN),
                    .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX),
                    .STEP_INC(STEP_INC)) u_step (
    .clk(clk), .rst(rst), .bclk_fall(bclk_fall), .apply_bit(bit_w),
    .clamp_active(clamp_w), .step(step_w), .overload(ovl_w)
  );

  cvsd_integrator #(.W(W), .FRAC(FRAC), .LEAK_SH(LEAK_SH)) u_integ (
    .clk(clk), .rst(rst), .bclk_fall(bclk_fall), .apply_bit(bit_w),
    .step(step_w), .est(est_w), .clamp_active(clamp_w)
  );

  assign est_out = est_w[EW-1:FRAC];
  assign eo_i    = int'(est_out);
  assign agc_n   = !((eo_i >= HALF) || (eo_i <= -HALF));
endmodule

// File: rtl/cvsd_codec_chk.sv
module cvsd_codec_chk #(
  parameter int W        = 12,
  parameter int FRAC     = 4,
  parameter int STEP_MIN = 4,
  parameter int STEP_MAX = 256,
  localparam int EW      = W + FRAC
) (
  input logic                clk,
  input logic                rst,
  input logic                bclk_fall,
  input logic                force_idle,
  input logic                serial_out,
  input logic                agc_n,
  input logic signed [W-1:0] est_out,
  input logic [EW-1:0]       step_w,
  input logic                clamp_w
);
  localparam int CLAMP = (1 << (W - 1)) * 3 / 4;
  logic prev_idle_fall;

  always_ff @(posedge clk) begin
    if (rst) prev_idle_fall <= 1'b0;
    else if (bclk_fall) prev_idle_fall <= force_idle;
  end

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    (!rst && $past(rst)) |-> (est_out == '0 && int'(step_w) == (STEP_MIN << FRAC)));
  a_r2_out_on_fall: assert property (@(posedge clk) disable iff (rst)
    !bclk_fall |=> $stable(serial_out));
  a_r4_est_on_fall: assert property (@(posedge clk) disable iff (rst)
    !bclk_fall |=> $stable(est_out));
  a_r5_step_bounds: assert property (@(posedge clk) disable iff (rst)
    int'(step_w) >= (STEP_MIN << FRAC) && int'(step_w) <= (STEP_MAX << FRAC));
  a_r6_agc_on_fall: assert property (@(posedge clk) disable iff (rst)
    !bclk_fall |=> $stable(agc_n));
  a_r7_est_window: assert property (@(posedge clk) disable iff (rst)
    int'(est_out) <= CLAMP && int'(est_out) >= -CLAMP);
  a_r7_step_frozen: assert property (@(posedge clk) disable iff (rst)
    (bclk_fall && clamp_w) |=> $stable(step_w));
  a_r8_idle_alt: assert property (@(posedge clk) disable iff (rst)
    (bclk_fall && force_idle && prev_idle_fall) |=> (serial_out != $past(serial_out)));
endmodule

bind cvsd_codec cvsd_codec_chk #(.W(W), .FRAC(FRAC), .STEP_MIN(STEP_MIN),
                                 .STEP_MAX(STEP_MAX)) u_chk (
  .clk(clk), .rst(rst), .bclk_fall(bclk_fall), .force_idle(force_idle),
  .serial_out(serial_out), .agc_n(agc_n), .est_out(est_out),
  .step_w(step_w), .clamp_w(clamp_w)
);

// File: tb/cvsd_codec_tb.sv
module cvsd_codec_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rise = 1'b0, fall = 1'b0, enc = 1'b1, sin = 1'b0, idle = 1'b0;
  logic signed [11:0] samp = '0;
  logic sout, agcn;
  logic signed [11:0] eout;

  always #2 clk = ~clk;

  cvsd_codec u_dut (
    .clk(clk), .rst(rst), .bclk_rise(rise), .bclk_fall(fall), .mode_enc(enc),
    .sample_in(samp), .serial_in(sin), .force_idle(idle),
    .serial_out(sout), .est_out(eout), .agc_n(agcn)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model, 1/16 LSB units
  int m_est, m_step, m_pend, m_tgl, m_out;
  int m_h0, m_h1;
  bit m_clamped;

  function automatic int fdiv(input int a, input int d);
    if (a >= 0) return a / d;
    return -((-a + d - 1) / d);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_est = 0; m_step = 64; m_pend = 0; m_tgl = 1; m_out = 0;
    m_h0 = 0; m_h1 = 1;
  endtask

  task automatic model_fall();
    int b, t, lim;
    lim = 1536 * 16;
    b = idle ? m_tgl : m_pend;
    if (idle) m_tgl = 1 - m_tgl;
    m_clamped = (m_est >= lim) || (m_est <= -lim);
    t = m_est - fdiv(m_est, 16);
    if (!m_clamped) begin
      t = t + (b == 1 ? m_step : -m_step);
      m_step = m_step - fdiv(m_step, 64) + ((b == m_h0 && b == m_h1) ? 128 : 0);
      if (m_step < 64) m_step = 64;
      if (m_step > 4096) m_step = 4096;
    end
    if (t > lim) t = lim;
    if (t < -lim) t = -lim;
    m_est = t;
    m_h1 = m_h0; m_h0 = b; m_out = b;
  endtask

  task automatic do_reset();
    rst = 1'b1; rise = 0; fall = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
    @(negedge clk);
  endtask

  // one bit period: rise strobe, gap, fall strobe, check
  task automatic do_bit(input bit e, input bit i, input bit d, input int s);
    int eo;
    enc = e; idle = i; sin = d; samp = 12'(s);
    rise = 1'b1;
    m_pend = e ? ((s * 16 >= m_est) ? 1 : 0) : int'(d);
    @(negedge clk); rise = 1'b0;
    @(negedge clk);
    chk("R2 out held before fall", int'(sout), m_out);
    fall = 1'b1;
    @(negedge clk); fall = 1'b0;
    model_fall();
    eo = fdiv(m_est, 16);
    chk(m_clamped ? "R7 clamped estimate" : "R4 estimate update", int'(eout), eo);
    chk(e ? "R2 encoded bit" : "R3 decoded bit", int'(sout), m_out);
    chk("R6 agc flag", int'(agcn), (eo >= 1024 || eo <= -1024) ? 0 : 1);
  endtask

  // {enc, idle, din, pad, sample[11:0], count[7:0]}
  localparam logic [23:0] VEC [12] = '{
    {4'b1000, 12'sd1500,  8'd30},
    {4'b1000, -12'sd1500, 8'd40},
    {4'b1000, 12'sd0,     8'd20},
    {4'b1000, 12'sd2047,  8'd90},
    {4'b1000, -12'sd2048, 8'd100},
    {4'b1000, 12'sd300,   8'd30},
    {4'b0010, 12'sd0,     8'd12},
    {4'b0000, 12'sd0,     8'd12},
    {4'b1100, 12'sd0,     8'd24},
    {4'b0010, 12'sd0,     8'd6},
    {4'b1000, -12'sd700,  8'd25},
    {4'b1000, 12'sd700,   8'd25}
  };

  int enc_est [48];
  int enc_bit [48];

  initial begin
    int prev_out, prev_est, mism, maxe, sawclamp;
    do_reset();
    // R1 reset state
    chk("R1 reset estimate", int'(eout), 0);
    chk("R1 reset serial_out", int'(sout), 0);
    chk("R1 reset agc_n", int'(agcn), 1);

    for (int v = 0; v < 12; v++) begin
      for (int k = 0; k < int'(VEC[v][7:0]); k++)
        do_bit(VEC[v][23], VEC[v][22], VEC[v][21], int'($signed(VEC[v][19:8])));
    end

    // R5 step: alternating decode bits keep step at minimum, estimate +-4 LSB region
    do_reset();
    for (int k = 0; k < 8; k++) do_bit(1'b0, 1'b0, k[0], 0);
    chk("R5 step stays minimum", m_step, 64);

    // R7 clamp: drive hard, observe window and return below threshold
    do_reset();
    maxe = 0; sawclamp = 0;
    for (int k = 0; k < 120; k++) begin
      do_bit(1'b1, 1'b0, 1'b0, 2047);
      if (int'(eout) > maxe) maxe = int'(eout);
      if (m_clamped) sawclamp++;
    end
    chk("R7 clamp reached", maxe, 1536);
    chk("R7 clamp entered", (sawclamp > 0) ? 1 : 0, 1);

    // R8 idle: output alternates each fall
    do_reset();
    do_bit(1'b0, 1'b1, 1'b0, 0);
    prev_out = int'(sout); prev_est = int'(eout);
    mism = 0;
    for (int k = 0; k < 30; k++) begin
      do_bit(1'b0, 1'b1, 1'b0, 0);
      if (int'(sout) == prev_out) mism++;
      if (k > 20 && int'(eout) == prev_est) mism++;
      prev_out = int'(sout); prev_est = int'(eout);
    end
    chk("R8 idle alternation", mism, 0);

    // R9 encoder stream replayed into decoder
    do_reset();
    for (int k = 0; k < 48; k++) begin
      do_bit(1'b1, 1'b0, 1'b0, ((k % 16) < 8) ? 40 * k : -30 * k);
      enc_est[k] = int'(eout); enc_bit[k] = int'(sout);
    end
    do_reset();
    mism = 0;
    for (int k = 0; k < 48; k++) begin
      do_bit(1'b0, 1'b0, enc_bit[k][0], 0);
      if (int'(eout) != enc_est[k]) mism++;
    end
    chk("R9 decoder tracks encoder", mism, 0);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule